// File: doc/BRIEF.md
# Circular Line Image Cache

This block keeps a band of image rows on chip so that a convolution engine can read pixels at any (row, column, channel) position without returning to external memory. Storage is a single block RAM with one write port and one read port. Each cached row occupies width × channels consecutive words, and within a row the channel index changes fastest. The total capacity is that row length times the number of cached lines.

Words arrive one per cycle from an external fetch unit. A row preload sequencer accepts exactly one row's worth of words after a start pulse, pixel by pixel, with all channels of a pixel in consecutive accepted words. A single flat write pointer advances through the whole buffer and wraps, so the lines form a ring and no per-line bookkeeping is needed. A counter of words still expected for the layer drops by the channel count each time a pixel completes.

The read side takes signed coordinates and a row base offset supplied by the caller. It returns the stored word one cycle later, or zero when the coordinate falls outside the image, so border padding comes for free. The image width, height and channel count are latched through a configuration strobe before each layer.

Top module: `line_cache`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `wr_addr` is 0, `busy` and `row_done` are 0, and `rd_out_valid` is 0 with `rd_data` 0.
- R2: A `cfg_load` pulse latches width, height and channel count, sets `loads_left` to width × height × channels, returns `wr_addr` to 0 and ends any preload in progress. All of this is visible on the next cycle.
- R3: Each accepted word is stored at `wr_addr`, after which `wr_addr` increments by one. After address width × channels × N_LINES − 1 it wraps to 0.
- R4: A `row_start` pulse while idle raises `busy` on the next cycle. The row accepts exactly width × channels words with `wr_valid`, and gaps are allowed between them. On the cycle after the last word, `busy` is 0 and `row_done` is 1 for exactly one cycle.
- R5: `loads_left` drops by the channel count on the cycle after a pixel's last channel word is accepted, and it saturates at 0. It never rises except through `cfg_load`.
- R6: Words presented with `wr_valid` while `busy` is 0 are ignored. `wr_addr` does not move and the RAM contents are unchanged.
- R7: A read request with `rd_valid` returns, on the next cycle, `rd_out_valid` = 1 together with the word stored at `rd_row_off` + `rd_x` × channels + `rd_ch`.
- R8: The read returns 0 when `rd_x` < 0, `rd_x` ≥ width, `rd_y` < 0 or `rd_y` ≥ height. Coordinates are two's-complement signed.
- R9: On the cycle after a cycle with no read request, `rd_out_valid` is 0 and `rd_data` is 0.
- R10: A `row_start` pulse that arrives while `busy` is 1 is ignored. The current row still ends after exactly width × channels words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Latch layer dimensions and restart the layer |
| cfg_width | input | W_W (5) | Image width in pixels |
| cfg_height | input | H_W (5) | Image height in rows |
| cfg_chans | input | CH_W (4) | Input channels per pixel |
| row_start | input | 1 | Begin preloading one row |
| wr_valid | input | 1 | Fetched word present on `wr_data` |
| wr_data | input | DATA_W (16) | Fetched word |
| busy | output | 1 | Row preload in progress, words accepted |
| row_done | output | 1 | One-cycle pulse after the last word of a row |
| loads_left | output | LOADS_W (12) | Words still expected for the layer |
| wr_addr | output | ADDR_W (9) | Current write address |
| rd_valid | input | 1 | Read request |
| rd_y | input | COORD_W (6) | Signed row coordinate |
| rd_x | input | COORD_W (6) | Signed column coordinate |
| rd_ch | input | CH_W (4) | Channel index |
| rd_row_off | input | ADDR_W (9) | Base address of the requested row's line |
| rd_out_valid | output | 1 | Read result present |
| rd_data | output | DATA_W (16) | Read result, zero for padding |

## Verification
Configuration, write address, remaining-load count, `busy` and `row_done` all change at the first rising edge after the stimulus that causes them. Read data and its valid flag appear at the rising edge after the request. The bench drives every input on the falling edge and compares at the next falling edge, which falls exactly one register stage later. It keeps its own image of the RAM and its own write pointer, advances them only for words it knows are accepted, and predicts every read result and padding case from those.

// File: rtl/lc_pkg.sv
package lc_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_ROW  = 1'b1
    } seq_state_t;

    // True when a signed coordinate lies outside the image
    function automatic logic coord_outside(input int y, input int x,
                                           input int h, input int w);
        return (x < 0) || (x >= w) || (y < 0) || (y >= h);
    endfunction

    // Last valid buffer address for a given geometry
    function automatic int ring_last(input int w, input int c, input int n);
        int prod;
        prod = w * c * n;
        return (prod == 0) ? 0 : prod - 1;
    endfunction

    // Flat address of one channel word inside a row
    function automatic int word_addr(input int base, input int x,
                                     input int chans, input int c);
        return base + x * chans + c;
    endfunction

endpackage

// File: rtl/lc_config.sv
module lc_config #(
    parameter int W_W     = 5,
    parameter int H_W     = 5,
    parameter int CH_W    = 4,
    parameter int ADDR_W  = 9,
    parameter int N_LINES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [W_W-1:0]    cfg_width,
    input  logic [H_W-1:0]    cfg_height,
    input  logic [CH_W-1:0]   cfg_chans,
    output logic [W_W-1:0]    width_q,
    output logic [H_W-1:0]    height_q,
    output logic [CH_W-1:0]   chans_q,
    output logic [ADDR_W-1:0] cap_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            width_q  <= '0;
            height_q <= '0;
            chans_q  <= '0;
            cap_last <= '0;
        end else if (cfg_load) begin
            width_q  <= cfg_width;
            height_q <= cfg_height;
            chans_q  <= cfg_chans;
            cap_last <= ADDR_W'(lc_pkg::ring_last(int'(cfg_width),
                                                  int'(cfg_chans), N_LINES));
        end
    end
endmodule

// File: rtl/lc_preload.sv
module lc_preload #(
    parameter int W_W     = 5,
    parameter int CH_W    = 4,
    parameter int ADDR_W  = 9,
    parameter int LOADS_W = 12,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_load,
    input  logic [LOADS_W-1:0] cfg_total,
    input  logic [W_W-1:0]     width_q,
    input  logic [CH_W-1:0]    chans_q,
    input  logic [ADDR_W-1:0]  cap_last,
    input  logic               row_start,
    input  logic               wr_valid,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               busy,
    output logic               row_done,
    output logic [LOADS_W-1:0] loads_left,
    output logic [ADDR_W-1:0]  wr_ptr,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_waddr,
    output logic [DATA_W-1:0]  mem_wdata
);
    import lc_pkg::*;

    seq_state_t         state;
    logic [CH_W-1:0]    ch_cnt;
    logic [W_W-1:0]     x_cnt;
    logic               accept;
    logic               pixel_end;
    logic               row_end;
    logic [LOADS_W-1:0] chans_ext;

    assign busy      = (state == SEQ_ROW);
    assign accept    = busy && wr_valid && !cfg_load;
    assign pixel_end = (ch_cnt == chans_q - 1'b1);
    assign row_end   = pixel_end && (x_cnt == width_q - 1'b1);
    assign chans_ext = LOADS_W'(chans_q);

    assign mem_we    = accept;
    assign mem_waddr = wr_ptr;
    assign mem_wdata = wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            ch_cnt     <= '0;
            x_cnt      <= '0;
            wr_ptr     <= '0;
            loads_left <= '0;
            row_done   <= 1'b0;
        end else begin
            row_done <= 1'b0;
            if (cfg_load) begin
                state      <= SEQ_IDLE;
                ch_cnt     <= '0;
                x_cnt      <= '0;
                wr_ptr     <= '0;
                loads_left <= cfg_total;
            end else begin
                unique case (state)
                    SEQ_IDLE: begin
                        if (row_start && (width_q != '0) && (chans_q != '0)) begin
                            state  <= SEQ_ROW;
                            ch_cnt <= '0;
                            x_cnt  <= '0;
                        end
                    end
                    SEQ_ROW: begin
                        if (accept) begin
                            wr_ptr <= (wr_ptr == cap_last) ? '0 : wr_ptr + 1'b1;
                            if (pixel_end) begin
                                ch_cnt     <= '0;
                                loads_left <= (loads_left > chans_ext) ?
                                              loads_left - chans_ext : '0;
                                if (row_end) begin
                                    state    <= SEQ_IDLE;
                                    x_cnt    <= '0;
                                    row_done <= 1'b1;
                                end else begin
                                    x_cnt <= x_cnt + 1'b1;
                                end
                            end else begin
                                ch_cnt <= ch_cnt + 1'b1;
                            end
                        end
                    end
                    default: state <= SEQ_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/lc_ram.sv
module lc_ram #(
    parameter int DEPTH  = 384,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH))
            store[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re && (int'(raddr) < DEPTH))
            rdata <= store[raddr];
    end
endmodule

// File: rtl/lc_reader.sv
module lc_reader #(
    parameter int W_W     = 5,
    parameter int H_W     = 5,
    parameter int CH_W    = 4,
    parameter int COORD_W = 6,
    parameter int ADDR_W  = 9,
    parameter int DATA_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [W_W-1:0]            width_q,
    input  logic [H_W-1:0]            height_q,
    input  logic [CH_W-1:0]           chans_q,
    input  logic                      rd_valid,
    input  logic signed [COORD_W-1:0] rd_y,
    input  logic signed [COORD_W-1:0] rd_x,
    input  logic [CH_W-1:0]           rd_ch,
    input  logic [ADDR_W-1:0]         rd_row_off,
    output logic                      ram_re,
    output logic [ADDR_W-1:0]         ram_raddr,
    input  logic [DATA_W-1:0]         ram_rdata,
    output logic                      rd_out_valid,
    output logic [DATA_W-1:0]         rd_data
);
    typedef struct packed {
        logic valid;
        logic pad;
    } rd_tag_t;

    rd_tag_t tag_q;
    logic    outside;

    assign outside   = lc_pkg::coord_outside(int'(rd_y), int'(rd_x),
                                             int'(height_q), int'(width_q));
    assign ram_re    = rd_valid && !outside;
    assign ram_raddr = ADDR_W'(lc_pkg::word_addr(int'(rd_row_off), int'(rd_x),
                                                 int'(chans_q), int'(rd_ch)));

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            tag_q.valid <= rd_valid;
            tag_q.pad   <= outside;
        end
    end

    assign rd_out_valid = tag_q.valid;
    assign rd_data      = (tag_q.valid && !tag_q.pad) ? ram_rdata : '0;
endmodule

// File: rtl/line_cache.sv
module line_cache #(
    parameter int DATA_W  = 16,
    parameter int N_LINES = 3,
    parameter int MAX_W   = 16,
    parameter int MAX_H   = 16,
    parameter int MAX_CH  = 8,
    localparam int W_W     = $clog2(MAX_W + 1),
    localparam int H_W     = $clog2(MAX_H + 1),
    localparam int CH_W    = $clog2(MAX_CH + 1),
    localparam int COORD_W = ((W_W > H_W) ? W_W : H_W) + 1,
    localparam int DEPTH   = MAX_W * MAX_CH * N_LINES,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int LOADS_W = $clog2(MAX_W * MAX_H * MAX_CH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_load,
    input  logic [W_W-1:0]            cfg_width,
    input  logic [H_W-1:0]            cfg_height,
    input  logic [CH_W-1:0]           cfg_chans,
    input  logic                      row_start,
    input  logic                      wr_valid,
    input  logic [DATA_W-1:0]         wr_data,
    output logic                      busy,
    output logic                      row_done,
    output logic [LOADS_W-1:0]        loads_left,
    output logic [ADDR_W-1:0]         wr_addr,
    input  logic                      rd_valid,
    input  logic signed [COORD_W-1:0] rd_y,
    input  logic signed [COORD_W-1:0] rd_x,
    input  logic [CH_W-1:0]           rd_ch,
    input  logic [ADDR_W-1:0]         rd_row_off,
    output logic                      rd_out_valid,
    output logic [DATA_W-1:0]         rd_data
);
    logic [W_W-1:0]     width_q;
    logic [H_W-1:0]     height_q;
    logic [CH_W-1:0]    chans_q;
    logic [ADDR_W-1:0]  cap_last;
    logic [LOADS_W-1:0] cfg_total;
    logic               mem_we;
    logic [ADDR_W-1:0]  mem_waddr;
    logic [DATA_W-1:0]  mem_wdata;
    logic               ram_re;
    logic [ADDR_W-1:0]  ram_raddr;
    logic [DATA_W-1:0]  ram_rdata;

    assign cfg_total = LOADS_W'(int'(cfg_width) * int'(cfg_height) * int'(cfg_chans));

    lc_config #(
        .W_W(W_W), .H_W(H_W), .CH_W(CH_W), .ADDR_W(ADDR_W), .N_LINES(N_LINES)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_load(cfg_load),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_chans(cfg_chans),
        .width_q(width_q), .height_q(height_q), .chans_q(chans_q),
        .cap_last(cap_last)
    );

    lc_preload #(
        .W_W(W_W), .CH_W(CH_W), .ADDR_W(ADDR_W), .LOADS_W(LOADS_W), .DATA_W(DATA_W)
    ) u_pre (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_total(cfg_total),
        .width_q(width_q), .chans_q(chans_q), .cap_last(cap_last),
        .row_start(row_start), .wr_valid(wr_valid), .wr_data(wr_data),
        .busy(busy), .row_done(row_done), .loads_left(loads_left),
        .wr_ptr(wr_addr), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );

    lc_ram #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_ram (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
    );

    lc_reader #(
        .W_W(W_W), .H_W(H_W), .CH_W(CH_W), .COORD_W(COORD_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_rd (
        .clk(clk), .rst(rst),
        .width_q(width_q), .height_q(height_q), .chans_q(chans_q),
        .rd_valid(rd_valid), .rd_y(rd_y), .rd_x(rd_x), .rd_ch(rd_ch),
        .rd_row_off(rd_row_off),
        .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
        .rd_out_valid(rd_out_valid), .rd_data(rd_data)
    );
endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
    parameter int ADDR_W  = 9,
    parameter int LOADS_W = 12,
    parameter int DATA_W  = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_load,
    input logic               wr_valid,
    input logic               busy,
    input logic               row_done,
    input logic [LOADS_W-1:0] loads_left,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [ADDR_W-1:0]  cap_last,
    input logic               rd_valid,
    input logic               rd_out_valid,
    input logic [DATA_W-1:0]  rd_data
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (wr_addr == '0 && !busy && !rd_out_valid && rd_data == '0));

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_valid && !cfg_load && wr_addr != cap_last)
        |=> wr_addr == ADDR_W'($past(wr_addr) + 1'b1));

    assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_valid && !cfg_load && wr_addr == cap_last) |=> wr_addr == '0);

    assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
        row_done |-> !busy);

    assert_loads_monotone_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> loads_left <= $past(loads_left));

    assert_idle_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cfg_load) |=> $stable(wr_addr));

    assert_read_latency_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> rd_out_valid);

    assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> (!rd_out_valid && rd_data == '0));
endmodule

bind line_cache lc_checker #(
    .ADDR_W(ADDR_W), .LOADS_W(LOADS_W), .DATA_W(DATA_W)
) u_lc_checker (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .wr_valid(wr_valid),
    .busy(busy), .row_done(row_done), .loads_left(loads_left),
    .wr_addr(wr_addr), .cap_last(cap_last), .rd_valid(rd_valid),
    .rd_out_valid(rd_out_valid), .rd_data(rd_data)
);

// File: tb/line_cache_bench.sv
module line_cache_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W  = 16;
    localparam int N_LINES = 3;
    localparam int MAX_W   = 16;
    localparam int MAX_H   = 16;
    localparam int MAX_CH  = 8;
    localparam int W_W     = $clog2(MAX_W + 1);
    localparam int H_W     = $clog2(MAX_H + 1);
    localparam int CH_W    = $clog2(MAX_CH + 1);
    localparam int COORD_W = ((W_W > H_W) ? W_W : H_W) + 1;
    localparam int DEPTH   = MAX_W * MAX_CH * N_LINES;
    localparam int ADDR_W  = $clog2(DEPTH);
    localparam int LOADS_W = $clog2(MAX_W * MAX_H * MAX_CH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_load = 1'b0;
    logic [W_W-1:0] cfg_width = '0;
    logic [H_W-1:0] cfg_height = '0;
    logic [CH_W-1:0] cfg_chans = '0;
    logic row_start = 1'b0;
    logic wr_valid = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic busy, row_done, rd_out_valid;
    logic [LOADS_W-1:0] loads_left;
    logic [ADDR_W-1:0] wr_addr;
    logic rd_valid = 1'b0;
    logic signed [COORD_W-1:0] rd_y = '0;
    logic signed [COORD_W-1:0] rd_x = '0;
    logic [CH_W-1:0] rd_ch = '0;
    logic [ADDR_W-1:0] rd_row_off = '0;
    logic [DATA_W-1:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int m_w, m_h, m_c, m_cap, m_ptr, m_loads;
    int model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    line_cache #(
        .DATA_W(DATA_W), .N_LINES(N_LINES), .MAX_W(MAX_W), .MAX_H(MAX_H), .MAX_CH(MAX_CH)
    ) u_line_cache (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .cfg_chans(cfg_chans), .row_start(row_start),
        .wr_valid(wr_valid), .wr_data(wr_data), .busy(busy), .row_done(row_done),
        .loads_left(loads_left), .wr_addr(wr_addr), .rd_valid(rd_valid),
        .rd_y(rd_y), .rd_x(rd_x), .rd_ch(rd_ch), .rd_row_off(rd_row_off),
        .rd_out_valid(rd_out_valid), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic bit pad_of(input int y, input int x);
        return (x < 0) || (x >= m_w) || (y < 0) || (y >= m_h);
    endfunction

    task automatic configure(input int w, input int h, input int c);
        cfg_width = W_W'(w); cfg_height = H_W'(h); cfg_chans = CH_W'(c);
        cfg_load = 1'b1;
        step();
        cfg_load = 1'b0;
        m_w = w; m_h = h; m_c = c; m_cap = w * c * N_LINES;
        m_ptr = 0; m_loads = w * h * c;
        chk("R2 loads", int'(loads_left), m_loads);
        chk("R2 addr", int'(wr_addr), 0);
        chk("R2 busy", int'(busy), 0);
    endtask

    task automatic preload_row(input bit extra_start);
        int n;
        n = m_w * m_c;
        row_start = 1'b1;
        step();
        row_start = 1'b0;
        chk("R4 busy rises", int'(busy), 1);
        for (int k = 0; k < n; k++) begin
            while ($urandom_range(3, 0) == 0) begin
                wr_valid = 1'b0;
                step();
            end
            wr_valid = 1'b1;
            wr_data = DATA_W'($urandom);
            row_start = (extra_start && k == n / 2);
            model[m_ptr] = int'(wr_data);
            m_ptr = (m_ptr + 1) % m_cap;
            step();
            wr_valid = 1'b0;
            row_start = 1'b0;
            chk("R3 addr", int'(wr_addr), m_ptr);
            if ((k + 1) % m_c == 0)
                m_loads = (m_loads > m_c) ? m_loads - m_c : 0;
            chk("R5 loads", int'(loads_left), m_loads);
            if (k < n - 1) begin
                chk(extra_start ? "R10 busy" : "R4 busy", int'(busy), 1);
            end else begin
                chk("R4 busy falls", int'(busy), 0);
                chk("R4 done", int'(row_done), 1);
            end
        end
        step();
        chk("R4 done pulse", int'(row_done), 0);
    endtask

    task automatic read_chk(input int y, input int x, input int c, input int off);
        int exp;
        rd_valid = 1'b1;
        rd_y = COORD_W'(y); rd_x = COORD_W'(x);
        rd_ch = CH_W'(c); rd_row_off = ADDR_W'(off);
        step();
        rd_valid = 1'b0;
        exp = pad_of(y, x) ? 0 : model[off + x * m_c + c];
        chk("R7 valid", int'(rd_out_valid), 1);
        chk(pad_of(y, x) ? "R8 pad" : "R7 data", int'(rd_data), exp);
    endtask

    task automatic random_reads(input int count);
        for (int i = 0; i < count; i++) begin
            read_chk(int'($urandom_range(m_h + 1, 0)) - 1,
                     int'($urandom_range(m_w + 1, 0)) - 1,
                     int'($urandom_range(m_c - 1, 0)),
                     int'($urandom_range(N_LINES - 1, 0)) * m_w * m_c);
            if ($urandom_range(3, 0) == 0) begin
                step();
                chk("R9 valid", int'(rd_out_valid), 0);
                chk("R9 data", int'(rd_data), 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        summary();
    end

    initial begin
        int probe_off, probe_x, probe_c, held;
        void'($urandom(32'd2718));
        for (int i = 0; i < DEPTH; i++) model[i] = 0;
        repeat (3) step();
        chk("R1 addr", int'(wr_addr), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 rvalid", int'(rd_out_valid), 0);
        rst = 1'b0;
        step();
        chk("R1 done", int'(row_done), 0);
        chk("R1 rdata", int'(rd_data), 0);

        configure(5, 4, 3);
        preload_row(1'b0);
        preload_row(1'b1);
        preload_row(1'b0);
        chk("R3 wrap", int'(wr_addr), 0);
        preload_row(1'b0);

        // R6: idle writes must not land
        held = m_ptr;
        for (int i = 0; i < 3; i++) begin
            wr_valid = 1'b1;
            wr_data = DATA_W'($urandom);
            step();
            chk("R6 addr", int'(wr_addr), held);
        end
        wr_valid = 1'b0;
        probe_off = (held / (m_w * m_c)) * m_w * m_c;
        probe_x = (held % (m_w * m_c)) / m_c;
        probe_c = held % m_c;
        read_chk(0, probe_x, probe_c, probe_off);

        // R10: start while idle works after a stray start during busy
        // R8 corners
        read_chk(0, -1, 0, 0);
        read_chk(0, m_w, 1, 0);
        read_chk(-1, 2, 2, 0);
        read_chk(m_h, 0, 0, 0);
        read_chk(m_h - 1, m_w - 1, m_c - 1, 2 * m_w * m_c);
        read_chk(0, 0, 0, 0);
        random_reads(200);

        configure(4, 2, 2);
        preload_row(1'b0);
        preload_row(1'b1);
        random_reads(100);
        step();
        summary();
    end
endmodule